// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Critical-Word Forwarding

This block sits between a processor read port and a slow main-memory read port. Every memory block of `WORDS` words has exactly one home slot, picked by the address bits just above the word offset. The remaining upper address bits form a tag that records which block the slot currently holds. A request whose slot is valid and whose tag matches is a hit, and the stored word comes back on the next cycle.

When a request misses, the block issues one burst read for the whole block. The burst starts at word 0 of that block and returns one word per beat. Every returning word is written into the slot. The word the processor asked for is handed back in the same cycle its beat arrives, without waiting for the rest of the burst. The processor stays stalled until the last beat is written. Only then are the slot's tag and valid bit updated, and new requests accepted again.

Two free-running counters record accepted hits and accepted misses. With them, the hit ratio of a reference stream can be measured from outside the block.

Top module: `dmc_cache`

## Requirements
- R1: After reset every slot is invalid, both counters read 0, `cpu_ready` is 1, and `cpu_rvalid` and `mem_req` are 0; the first access to any block is therefore a miss.
- R2: A request accepted on a hit (`cpu_req` and `cpu_ready` both high at a clock edge) raises `cpu_rvalid` in the following cycle with the stored word on `cpu_rdata`.
- R3: A miss raises `mem_req` with `mem_addr` equal to the block base (requested address with its low log2(WORDS) bits cleared), and holds both steady until `mem_ack` is sampled high.
- R4: During the refill the requested word is returned on `cpu_rdata` with `cpu_rvalid` high in exactly the cycle its beat is presented with `mem_dvalid` (beat k carries block word k), while `cpu_ready` is still 0.
- R5: After the sixteenth beat of a default-geometry refill, `cpu_ready` returns to 1 in the next cycle and every word of the block then hits with the data delivered by memory.
- R6: The slot index is address bits [5:4] and the tag is bits [AW-1:6] (default geometry); two blocks with the same slot bits evict each other, while a block in another slot stays resident.
- R7: `hit_count` increments by exactly one per accepted hit and `miss_count` by exactly one per accepted miss; neither changes otherwise.
- R8: From the cycle after a miss is accepted until its refill finishes, `cpu_ready` is 0 and no request is accepted.
- R9: From an empty cache, reading words 48 to 95 once and then 15 to 31 ten times gives 5 misses and 213 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | AW | Processor word address |
| cpu_ready | output | 1 | Block can accept a request this cycle |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DW | Read data |
| mem_req | output | 1 | Burst read request to memory |
| mem_addr | output | AW | Block base word address of the burst |
| mem_ack | input | 1 | Memory accepted the burst request |
| mem_dvalid | input | 1 | A burst beat is present on mem_data |
| mem_data | input | DW | Burst beat data, word 0 first |
| hit_count | output | CW | Accepted hits since reset |
| miss_count | output | CW | Accepted misses since reset |

## Verification
The bench builds the block with its default geometry: 16-bit word addresses, 32-bit data, four slots of 16 words and 16-bit counters. Its memory model has a latency of 4 cycles from acknowledge to the first beat. This geometry makes the 48-to-95 / 15-to-31 loop program meaningful. It also puts the first word and the last word of a block within reach as critical words. The latency keeps the stall long enough to watch `cpu_ready` stay low across the burst. A slot collision is reachable with a few hand-picked addresses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } fill_state_t;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int SLOTS = 4,
  parameter int TW    = 10,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_slot,
  output logic [TW-1:0] rd_tag,
  output logic          rd_valid,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [TW-1:0] wr_tag
);

  logic [TW-1:0]    tag_q   [SLOTS];
  logic [SLOTS-1:0] valid_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (wr_en && (wr_slot == SW'(i))) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= wr_tag;
      end
    end
  end

  assign rd_tag   = tag_q[rd_slot];
  assign rd_valid = valid_q[rd_slot];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) line_q[wr_idx] <= wr_data;
  end

  assign rd_data = line_q[rd_idx];

endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
  import dmc_pkg::*;
#(
  parameter int TW  = 10,
  parameter int SW  = 2,
  parameter int OFF = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_req,
  input  logic           lookup_hit,
  input  logic [TW-1:0]  req_tag,
  input  logic [SW-1:0]  req_slot,
  input  logic [OFF-1:0] req_word,
  input  logic           mem_ack,
  input  logic           mem_dvalid,
  output logic           cpu_ready,
  output logic           acc_hit,
  output logic           acc_miss,
  output logic           mem_req,
  output logic [TW-1:0]  fill_tag,
  output logic [SW-1:0]  fill_slot,
  output logic [OFF-1:0] fill_beat,
  output logic           fill_we,
  output logic           fill_resp,
  output logic           fill_last
);

  fill_state_t    state_q;
  logic [TW-1:0]  tag_q;
  logic [SW-1:0]  slot_q;
  logic [OFF-1:0] word_q;
  logic [OFF-1:0] beat_q;
  logic           resp_sent_q;
  logic           accept;

  assign cpu_ready = (state_q == ST_IDLE);
  assign accept    = cpu_req && cpu_ready;
  assign acc_hit   = accept && lookup_hit;
  assign acc_miss  = accept && !lookup_hit;
  assign mem_req   = (state_q == ST_REQ);
  assign fill_we   = (state_q == ST_FILL) && mem_dvalid;
  assign fill_resp = fill_we && (beat_q == word_q);
  assign fill_last = fill_we && (&beat_q);
  assign fill_tag  = tag_q;
  assign fill_slot = slot_q;
  assign fill_beat = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      slot_q      <= '0;
      word_q      <= '0;
      beat_q      <= '0;
      resp_sent_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_miss) begin
            tag_q       <= req_tag;
            slot_q      <= req_slot;
            word_q      <= req_word;
            beat_q      <= '0;
            resp_sent_q <= 1'b0;
            state_q     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_ack) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (fill_we) begin
            beat_q <= beat_q + 1'b1;
            if (fill_resp) resp_sent_q <= 1'b1;
            if (fill_last) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the critical word has gone out by the time the last beat lands
  a_r4_resp_by_last: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> (resp_sent_q || fill_resp));

  // R8: a missed request closes the door on the next cycle
  a_r8_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> !cpu_ready);

  // R8: beats are only consumed while no request can be taken
  a_r8_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !accept);

endmodule

// File: rtl/dmc_stats.sv
module dmc_stats #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_ev,
  input  logic          miss_ev,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (hit_ev)  hit_count  <= hit_count + 1'b1;
      if (miss_ev) miss_count <= miss_count + 1'b1;
    end
  end

  a_r7_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (hit_count == $past(hit_count) + 1'b1));

  a_r7_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ev |=> $stable(hit_count));

  a_r7_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> (miss_count == $past(miss_count) + 1'b1));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_ev, miss_ev}) <= 1);

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WORDS = 16,
  parameter int SLOTS = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_dvalid,
  input  logic [DW-1:0] mem_data,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);

  localparam int OFF = $clog2(WORDS);
  localparam int SW  = $clog2(SLOTS);
  localparam int TW  = AW - OFF - SW;
  localparam int IW  = SW + OFF;

  // address arithmetic kept in one place
  function automatic logic [OFF-1:0] word_of(logic [AW-1:0] a);
    return a[OFF-1:0];
  endfunction

  function automatic logic [SW-1:0] slot_of(logic [AW-1:0] a);
    return a[OFF +: SW];
  endfunction

  function automatic logic [TW-1:0] tag_of(logic [AW-1:0] a);
    return a[AW-1 -: TW];
  endfunction

  function automatic logic [AW-1:0] block_base(logic [TW-1:0] t, logic [SW-1:0] s);
    return {t, s, {OFF{1'b0}}};
  endfunction

  function automatic logic [IW-1:0] line_index(logic [SW-1:0] s, logic [OFF-1:0] w);
    return {s, w};
  endfunction

  // named internal events
  logic [TW-1:0]  look_tag;
  logic           look_valid;
  logic           lookup_hit;
  logic           acc_hit;
  logic           acc_miss;
  logic [TW-1:0]  fill_tag;
  logic [SW-1:0]  fill_slot;
  logic [OFF-1:0] fill_beat;
  logic           fill_we;
  logic           fill_resp;
  logic           fill_last;
  logic [DW-1:0]  stored_word;
  logic           hit_rvalid_q;
  logic [DW-1:0]  hit_rdata_q;

  dmc_tag_store #(.SLOTS(SLOTS), .TW(TW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_slot  (slot_of(cpu_addr)),
    .rd_tag   (look_tag),
    .rd_valid (look_valid),
    .wr_en    (fill_last),
    .wr_slot  (fill_slot),
    .wr_tag   (fill_tag)
  );

  assign lookup_hit = look_valid && (look_tag == tag_of(cpu_addr));

  dmc_data_store #(.DEPTH(SLOTS * WORDS), .DW(DW)) u_data (
    .clk     (clk),
    .we      (fill_we),
    .wr_idx  (line_index(fill_slot, fill_beat)),
    .wr_data (mem_data),
    .rd_idx  (line_index(slot_of(cpu_addr), word_of(cpu_addr))),
    .rd_data (stored_word)
  );

  dmc_refill_ctrl #(.TW(TW), .SW(SW), .OFF(OFF)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .lookup_hit (lookup_hit),
    .req_tag    (tag_of(cpu_addr)),
    .req_slot   (slot_of(cpu_addr)),
    .req_word   (word_of(cpu_addr)),
    .mem_ack    (mem_ack),
    .mem_dvalid (mem_dvalid),
    .cpu_ready  (cpu_ready),
    .acc_hit    (acc_hit),
    .acc_miss   (acc_miss),
    .mem_req    (mem_req),
    .fill_tag   (fill_tag),
    .fill_slot  (fill_slot),
    .fill_beat  (fill_beat),
    .fill_we    (fill_we),
    .fill_resp  (fill_resp),
    .fill_last  (fill_last)
  );

  dmc_stats #(.CW(CW)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_ev     (acc_hit),
    .miss_ev    (acc_miss),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_rvalid_q <= 1'b0;
      hit_rdata_q  <= '0;
    end else begin
      hit_rvalid_q <= acc_hit;
      if (acc_hit) hit_rdata_q <= stored_word;
    end
  end

  assign mem_addr   = block_base(fill_tag, fill_slot);
  assign cpu_rvalid = hit_rvalid_q || fill_resp;
  assign cpu_rdata  = fill_resp ? mem_data : hit_rdata_q;

  // R2: a hit answers on the next cycle
  a_r2_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> cpu_rvalid);

  // R3: the burst request waits for acknowledge without moving
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R3: the burst always starts on a block boundary
  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (word_of(mem_addr) == '0));

  // R1: out of reset no response and no burst are pending
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> (!cpu_rvalid && !mem_req && cpu_ready));

endmodule

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;

  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int CW  = 16;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready;
  logic          cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic          mem_dvalid = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic [CW-1:0] hit_count;
  logic [CW-1:0] miss_count;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [AW-1:0] last_base = '0;
  int bursts = 0;

  always #4 clk = ~clk;

  dmc_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_dvalid(mem_dvalid), .mem_data(mem_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: ack, LAT cycles, then 16 beats from word 0
  initial begin
    logic [AW-1:0] base;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req === 1'b1) begin
        base = mem_addr;
        last_base = base;
        bursts++;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        for (int b = 0; b < 16; b++) begin
          mem_dvalid = 1'b1;
          mem_data = mem_word(base + AW'(b));
          @(negedge clk);
        end
        mem_dvalid = 1'b0;
      end
    end
  end

  task automatic access(input logic [AW-1:0] a, output logic [DW-1:0] d,
                        output int lat, output logic rdy);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1;
    cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    #1;
    while (!cpu_rvalid && lat < 1000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    d = cpu_rdata;
    rdy = cpu_ready;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
    check(cpu_rvalid == 1'b0 && mem_req == 1'b0, "R1 idle outputs", {cpu_rvalid, mem_req}, 0);
    check(hit_count == 0 && miss_count == 0, "R1 counters", {hit_count, miss_count}, 0);
  endtask

  task automatic t_cold_miss();
    logic [DW-1:0] d; int lat; logic rdy;
    access(16'h0123, d, lat, rdy);
    check(d == mem_word(16'h0123), "R4 critical word data", d, mem_word(16'h0123));
    check(lat == LAT + 3 + 1, "R4 critical word timing", lat, LAT + 4);
    check(rdy == 1'b0, "R4 ready low at forward", rdy, 0);
    check(last_base == 16'h0120, "R3 burst base", last_base, 16'h0120);
    check(miss_count == 1 && hit_count == 0, "R7 miss counted", {hit_count, miss_count}, 1);
  endtask

  task automatic t_block_hits();
    logic [DW-1:0] d; int lat; logic rdy;
    logic [AW-1:0] list [3] = '{16'h012F, 16'h0120, 16'h0127};
    foreach (list[i]) begin
      access(list[i], d, lat, rdy);
      check(d == mem_word(list[i]), "R5 hit data after fill", d, mem_word(list[i]));
      check(lat == 1, "R2 hit latency", lat, 1);
    end
    check(hit_count == 3 && miss_count == 1, "R7 hits counted", {hit_count, miss_count}, {16'd3, 16'd1});
  endtask

  task automatic t_last_beat();
    logic [DW-1:0] d; int lat; logic rdy;
    access(16'h034F, d, lat, rdy);
    check(d == mem_word(16'h034F), "R4 last word data", d, mem_word(16'h034F));
    check(lat == LAT + 15 + 1, "R4 last word timing", lat, LAT + 16);
    check(last_base == 16'h0340, "R3 burst base last", last_base, 16'h0340);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] d; int lat; logic rdy;
    int m0;
    m0 = miss_count;
    access(16'h0523, d, lat, rdy);
    check(lat > 1 && d == mem_word(16'h0523), "R6 same slot new tag misses", lat, LAT + 4);
    access(16'h0123, d, lat, rdy);
    check(lat > 1 && d == mem_word(16'h0123), "R6 evicted block misses", lat, LAT + 4);
    access(16'h0124, d, lat, rdy);
    check(lat == 1 && d == mem_word(16'h0124), "R6 refetched block hits", lat, 1);
    access(16'h0341, d, lat, rdy);
    check(lat == 1 && d == mem_word(16'h0341), "R6 other slot untouched", lat, 1);
    check(int'(miss_count) == m0 + 2, "R7 conflict misses", miss_count, m0 + 2);
  endtask

  task automatic t_busy();
    logic [DW-1:0] d; int lat; logic rdy;
    int c; int h0; int m0;
    h0 = hit_count; m0 = miss_count;
    access(16'h0770, d, lat, rdy);
    check(lat == LAT + 1 && d == mem_word(16'h0770), "R4 word 0 forward", lat, LAT + 1);
    // hold a request through the rest of the refill; it must wait
    cpu_addr = 16'h0771;
    cpu_req = 1'b1;
    c = 0;
    while (!cpu_ready && c < 100) begin
      @(negedge clk);
      #1;
      c++;
    end
    cpu_req = 1'b0;
    check(c == 16, "R8 stall length", c, 16);
    check(int'(hit_count) == h0 && int'(miss_count) == m0 + 1, "R8 nothing accepted in refill",
          {hit_count, miss_count}, {h0[15:0], 16'(m0 + 1)});
    access(16'h077F, d, lat, rdy);
    check(lat == 1 && d == mem_word(16'h077F), "R5 ready again and hits", lat, 1);
  endtask

  task automatic t_program();
    logic [DW-1:0] d; int lat; logic rdy;
    int bad = 0;
    do_reset();
    check(miss_count == 0 && hit_count == 0, "R1 counters cleared", {hit_count, miss_count}, 0);
    for (int a = 48; a <= 95; a++) begin
      access(AW'(a), d, lat, rdy);
      if (d != mem_word(AW'(a))) bad++;
    end
    for (int n = 0; n < 10; n++)
      for (int a = 15; a <= 31; a++) begin
        access(AW'(a), d, lat, rdy);
        if (d != mem_word(AW'(a))) bad++;
      end
    check(bad == 0, "R9 program data", bad, 0);
    check(miss_count == 5, "R9 program misses", miss_count, 5);
    check(hit_count == 213, "R9 program hits", hit_count, 213);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cold_miss();
    t_block_hits();
    t_last_beat();
    t_conflict();
    t_busy();
    t_program();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule